// File: doc/BRIEF.md
# Compare and Condition Field Unit

This block holds a condition register made of eight 4-bit fields and writes one field per cycle from a compare of two operands. A compare can be signed or unsigned. A third form masks the register operand to its low word and the immediate to its low half-word, then compares them as unsigned values. A record-form update compares an arithmetic result with zero and always writes field 0, whatever field index is applied.

Field 0 also serves branch queries. A 3-bit condition selects one of six relational tests, and each test reads one bit of field 0, either directly or inverted. The answer is combinational from the registered field. A query therefore sees the value from before any update made in the same cycle. Field 0 is also presented zero-extended on a data-width output, so that a move-from-condition operation can copy it into a register.

Inside a field the flags are numbered from the most significant end: less-than is index 0, greater-than is index 1 and equal is index 2. The physical bit of a flag is 3 minus its index. The lowest bit of each field is never written and stays 0.

Top module: `crf_unit`

## Requirements
- R1: After reset every bit of `cr_o` and `mf_o` is 0. Branch conditions LT, GT and EQ are then not taken, and GE, LE and NE are taken.
- R2: A write leaves exactly one of the field's bits 3 (less-than), 2 (greater-than) and 1 (equal) set, and field bit 0 is 0. Less-than takes priority over greater-than, and equal is set only when neither holds.
- R3: Op code 1 compares `a_i` with `b_i` as two's-complement numbers and writes field `fld_i`.
- R4: Op code 2 compares `a_i` with `b_i` as unsigned numbers and writes field `fld_i`.
- R5: Op code 3 compares the low 32 bits of `a_i` with the low 16 bits of `b_i`, both zero-extended, as unsigned numbers. All higher bits have no effect.
- R6: Op code 4 compares `a_i` with zero as a signed number and writes field 0. `fld_i` is ignored.
- R7: Field f occupies `cr_o[31-4f -: 4]`, so field 0 is the top nibble.
- R8: A write changes only its target field. Op codes 0, 5, 6 and 7 change nothing.
- R9: `br_cond_i` codes are 0 LT, 1 GE, 2 GT, 3 LE, 4 EQ and 5 NE. LT, GT and EQ are taken when field-0 bit 3, 2 or 1 is set. GE, LE and NE are taken when that same bit is clear. Codes 6 and 7 are never taken.
- R10: Updates take effect at the rising clock edge. A branch query in the cycle of an update sees the previous field 0.
- R11: `mf_o` equals field 0 zero-extended to `DATA_W` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation: 0 none, 1 signed, 2 unsigned, 3 word/half-word unsigned, 4 record vs zero |
| fld_i | input | 3 | Target field index for op codes 1 to 3 |
| a_i | input | 64 | First operand or arithmetic result |
| b_i | input | 64 | Second operand or immediate |
| br_cond_i | input | 3 | Branch condition code |
| cr_o | output | 32 | Whole condition register |
| br_taken_o | output | 1 | Branch condition outcome on field 0 |
| mf_o | output | 64 | Field 0, zero-extended |

## Verification
On every cycle the assertions check three things: that a written field holds a single flag with its low bit clear, that fields not targeted keep their value, and that equal operands or a zero record result yield the equal flag. Only the directed scenarios can show the exact flag chosen for ordered operands. The same holds for signed versus unsigned ordering, the effect of the masking in the immediate form, field placement within `cr_o`, each branch code's outcome, and the fact that a query made in the cycle of an update still reads the old field.

// File: rtl/crf_pkg.sv
package crf_pkg;
    localparam int FIELD_W = 4;
    // flag indices counted from the most significant end of a field
    localparam int IDX_LT = 0;
    localparam int IDX_GT = 1;
    localparam int IDX_EQ = 2;
    localparam int POS_LT = FIELD_W - 1 - IDX_LT;
    localparam int POS_GT = FIELD_W - 1 - IDX_GT;
    localparam int POS_EQ = FIELD_W - 1 - IDX_EQ;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_CMP_S  = 3'd1,
        OP_CMP_U  = 3'd2,
        OP_CMP_LI = 3'd3,
        OP_REC    = 3'd4
    } crf_op_e;

    typedef enum logic [2:0] {
        BR_LT = 3'd0,
        BR_GE = 3'd1,
        BR_GT = 3'd2,
        BR_LE = 3'd3,
        BR_EQ = 3'd4,
        BR_NE = 3'd5
    } crf_br_e;
endpackage

// File: rtl/crf_cmp.sv
module crf_cmp
    import crf_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32,
    parameter int IMM_W  = 16
) (
    input  crf_op_e               op_i,
    input  logic [DATA_W-1:0]     a_i,
    input  logic [DATA_W-1:0]     b_i,
    output logic [FIELD_W-1:0]    nib_o
);
    logic [DATA_W-1:0] a_x, b_x;
    logic              sgn, lt, gt;

    always_comb begin
        a_x = a_i;
        b_x = b_i;
        sgn = 1'b0;
        unique case (op_i)
            OP_CMP_S:  sgn = 1'b1;
            OP_CMP_U:  sgn = 1'b0;
            OP_CMP_LI: begin
                a_x = DATA_W'(a_i[WORD_W-1:0]);
                b_x = DATA_W'(b_i[IMM_W-1:0]);
            end
            OP_REC: begin
                sgn = 1'b1;
                b_x = '0;
            end
            default: sgn = 1'b0;
        endcase
    end

    always_comb begin
        lt = sgn ? ($signed(a_x) < $signed(b_x)) : (a_x < b_x);
        gt = sgn ? ($signed(a_x) > $signed(b_x)) : (a_x > b_x);
        nib_o = '0;
        if (lt)      nib_o[POS_LT] = 1'b1;
        else if (gt) nib_o[POS_GT] = 1'b1;
        else         nib_o[POS_EQ] = 1'b1;
    end
endmodule

// File: rtl/crf_branch.sv
module crf_branch
    import crf_pkg::*;
(
    input  logic [FIELD_W-1:0] f0_i,
    input  logic [2:0]         cond_i,
    output logic               taken_o
);
    always_comb begin
        case (cond_i)
            BR_LT:   taken_o =  f0_i[POS_LT];
            BR_GE:   taken_o = !f0_i[POS_LT];
            BR_GT:   taken_o =  f0_i[POS_GT];
            BR_LE:   taken_o = !f0_i[POS_GT];
            BR_EQ:   taken_o =  f0_i[POS_EQ];
            BR_NE:   taken_o = !f0_i[POS_EQ];
            default: taken_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/crf_unit.sv
module crf_unit
    import crf_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int NFIELDS = 8,
    parameter int WORD_W  = 32,
    parameter int IMM_W   = 16
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [2:0]                                op_i,
    input  logic [(NFIELDS>1?$clog2(NFIELDS):1)-1:0]  fld_i,
    input  logic [DATA_W-1:0]                         a_i,
    input  logic [DATA_W-1:0]                         b_i,
    input  logic [2:0]                                br_cond_i,
    output logic [NFIELDS*FIELD_W-1:0]                cr_o,
    output logic                                      br_taken_o,
    output logic [DATA_W-1:0]                         mf_o
);
    localparam int IDX_W = (NFIELDS > 1) ? $clog2(NFIELDS) : 1;
    localparam int CR_W  = NFIELDS * FIELD_W;

    crf_op_e            op;
    logic               wr;
    logic [IDX_W-1:0]   tgt;
    logic [FIELD_W-1:0] nib;
    logic [FIELD_W-1:0] fld_q [NFIELDS];

    assign op = crf_op_e'(op_i);

    always_comb begin
        unique case (op)
            OP_CMP_S, OP_CMP_U, OP_CMP_LI, OP_REC: wr = 1'b1;
            default:                               wr = 1'b0;
        endcase
        tgt = (op == OP_REC) ? '0 : fld_i;
    end

    crf_cmp #(.DATA_W(DATA_W), .WORD_W(WORD_W), .IMM_W(IMM_W)) u_cmp (
        .op_i  (op),
        .a_i   (a_i),
        .b_i   (b_i),
        .nib_o (nib)
    );

    for (genvar g = 0; g < NFIELDS; g++) begin : g_field
        localparam int HI = CR_W - 1 - g * FIELD_W;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                fld_q[g] <= '0;
            else if (wr && tgt == IDX_W'(g))
                fld_q[g] <= nib;
        end

        assign cr_o[HI -: FIELD_W] = fld_q[g];

        AST_OTHER_FIELD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr || tgt != IDX_W'(g)) |=> $stable(fld_q[g])); // R8
        AST_WRITE_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && tgt == IDX_W'(g)) |=> ($countones(cr_o[HI -: FIELD_W-1]) == 1
                                         && !cr_o[HI-FIELD_W+1])); // R2
    end

    crf_branch u_br (
        .f0_i    (fld_q[0]),
        .cond_i  (br_cond_i),
        .taken_o (br_taken_o)
    );

    assign mf_o = {{(DATA_W-FIELD_W){1'b0}}, fld_q[0]};

    AST_RECORD_ZERO_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_REC && a_i == '0) |=> (cr_o[CR_W-1 -: FIELD_W] == 4'b0010)); // R6
    AST_EQUAL_OPS_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_CMP_S || op == OP_CMP_U) && a_i == b_i)
            |=> (fld_q[$past(tgt)] == 4'b0010)); // R3
endmodule

// File: tb/sim_crf_unit.sv
module sim_crf_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [2:0]  fld_i = 3'd0;
    logic [63:0] a_i = '0;
    logic [63:0] b_i = '0;
    logic [2:0]  br_cond_i = 3'd0;
    logic [31:0] cr_o;
    logic        br_taken_o;
    logic [63:0] mf_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crf_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .fld_i(fld_i), .a_i(a_i), .b_i(b_i),
        .br_cond_i(br_cond_i), .cr_o(cr_o), .br_taken_o(br_taken_o), .mf_o(mf_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // apply one operation for one cycle, then sample after the edge
    task automatic do_op(input logic [2:0] op, input logic [2:0] f,
                         input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        op_i = op; fld_i = f; a_i = a; b_i = b;
        @(posedge clk); #1;
        op_i = 3'd0;
    endtask

    task automatic br_check(input logic [2:0] c, input logic exp, input string req);
        @(negedge clk);
        br_cond_i = c; #1;
        check(req, {63'd0, br_taken_o}, {63'd0, exp});
    endtask

    task automatic t_reset;
        check("R1 cr", {32'd0, cr_o}, 64'd0);
        check("R1 mf", mf_o, 64'd0);
        br_check(3'd0, 1'b0, "R1 LT");
        br_check(3'd1, 1'b1, "R1 GE");
        br_check(3'd5, 1'b1, "R1 NE");
    endtask

    task automatic t_signed_unsigned;
        do_op(3'd1, 3'd2, -64'sd5, 64'd3);
        check("R3 signed lt field2", {32'd0, cr_o}, 64'h0080_0000);
        do_op(3'd2, 3'd2, -64'sd5, 64'd3);
        check("R4 unsigned gt field2", {32'd0, cr_o}, 64'h0040_0000);
        do_op(3'd1, 3'd7, 64'd123, 64'd123);
        check("R7 eq field7", {32'd0, cr_o}, 64'h0040_0002);
    endtask

    task automatic t_logical_imm;
        do_op(3'd3, 3'd0, 64'hFFFF_FFFF_0000_0005, 64'h0000_0000_0001_0005);
        check("R5 masked eq", {32'd0, cr_o}, 64'h2040_0002);
        do_op(3'd3, 3'd0, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R5 masked gt", {32'd0, cr_o}, 64'h4040_0002);
    endtask

    task automatic t_record;
        do_op(3'd4, 3'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'd9);
        check("R6 record lt", {32'd0, cr_o}, 64'h8040_0002);
        check("R11 mf", mf_o, 64'd8);
        do_op(3'd4, 3'd5, 64'd0, 64'd9);
        check("R6 record eq", {32'd0, cr_o}, 64'h2040_0002);
        do_op(3'd4, 3'd3, 64'd7, 64'd0);
        check("R6 record gt", {32'd0, cr_o}, 64'h4040_0002);
    endtask

    task automatic t_branch;
        br_check(3'd0, 1'b0, "R9 LT");
        br_check(3'd1, 1'b1, "R9 GE");
        br_check(3'd2, 1'b1, "R9 GT");
        br_check(3'd3, 1'b0, "R9 LE");
        br_check(3'd4, 1'b0, "R9 EQ");
        br_check(3'd5, 1'b1, "R9 NE");
        br_check(3'd6, 1'b0, "R9 code6");
        br_check(3'd7, 1'b0, "R9 code7");
    endtask

    task automatic t_ignored;
        do_op(3'd6, 3'd1, 64'd1, 64'd2);
        check("R8 op6 ignored", {32'd0, cr_o}, 64'h4040_0002);
        do_op(3'd0, 3'd1, 64'd1, 64'd2);
        check("R8 op0 ignored", {32'd0, cr_o}, 64'h4040_0002);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        op_i = 3'd1; fld_i = 3'd0; a_i = 64'd1; b_i = 64'd2; br_cond_i = 3'd0;
        #1;
        check("R10 old value seen", {63'd0, br_taken_o}, 64'd0);
        @(posedge clk); #1;
        op_i = 3'd0;
        check("R10 new value after edge", {63'd0, br_taken_o}, 64'd1);
        check("R10 cr", {32'd0, cr_o}, 64'h8040_0002);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 2 + 2);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_signed_unsigned();
        t_logical_imm();
        t_record();
        t_branch();
        t_ignored();
        t_same_cycle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule